// File: doc/BRIEF.md
# Remote Terminal Status Word Builder

This block builds the 16-bit status word that a serial-bus remote terminal sends back after it serves a command. Host-side strobes feed it: an illegal-command flag, a service-request flag and an accept-bus-control flag, all active low. Internal conditions feed it as well: a word count mismatch, a valid bus-control mode command indication, a self-test failure and a watchdog timeout. A one-cycle update strobe loads a new word into the status register. The register holds that word until the next strobe.

The block also keeps an active-low terminal failure latch. Either fault source sets it. It clears at the start of the next status transmission, unless a fault is still present in that cycle. Serial transmission and the self-test logic are not part of this block.

All inputs are sampled on the rising clock edge. Every result is registered and shows on the outputs in the cycle after the edge that sampled its cause.

Top module: `rt_status_builder`

## Requirements
- R1: After a synchronous reset, `status_word` is 0 and `rt_fail_n` is 1.
- R2: On a clock edge with `status_update` high, `status_word` takes the layout bits 15:11 = `rt_addr`, bit 10 = message error, bit 8 = service request, bit 1 = bus control acceptance and bit 0 = terminal flag. Bits 9 and 7:2 are 0.
- R3: Bit 8 of the loaded word is 1 if `svc_req_n` is 0 at the update edge, and 0 if it is 1.
- R4: At the first edge where `in_cmd` is 1 after an edge where it was 0 (a rising edge of `in_cmd`), a 0 on `illegal_n` sets the message error state. A later update then loads bit 10 as 1.
- R5: `wc_mismatch` high at an edge also sets the message error state. `cmd_accept` high at an edge clears it. When a set and a clear occur at the same edge, the set wins.
- R6: Bit 1 of the loaded word is 1 only when, at the update edge, `dbc_accept_n` is 0, `dbc_cmd_valid` is 1, and the illegal flag captured at the last rising edge of `in_cmd` is clear.
- R7: If `self_test_fail` or `wd_timeout` is high at an edge, `rt_fail_n` is 0 after that edge.
- R8: `status_tx_start` high at an edge with no fault input high sets `rt_fail_n` to 1 after that edge. If a fault is present at the same edge, `rt_fail_n` stays 0.
- R9: On an edge with `status_update` low, `status_word` keeps its value.
- R10: Bit 0 of the loaded word equals the failure latch state (1 = failed) just before the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_addr | input | 5 | Assigned terminal address |
| in_cmd | input | 1 | High while a command is being served |
| cmd_accept | input | 1 | Pulse: a valid command was accepted; clears message error |
| illegal_n | input | 1 | Active-low illegal-command flag, captured on in_cmd rise |
| wc_mismatch | input | 1 | Pulse: word count mismatch detected |
| svc_req_n | input | 1 | Active-low service request, sampled at update |
| dbc_accept_n | input | 1 | Active-low accept of dynamic bus control |
| dbc_cmd_valid | input | 1 | Current command is a valid bus-control mode command |
| self_test_fail | input | 1 | Continuous self-test failure |
| wd_timeout | input | 1 | Watchdog timeout |
| status_update | input | 1 | One-cycle strobe that loads the status word |
| status_tx_start | input | 1 | Start of status word transmission |
| status_word | output | 16 | Registered status word |
| rt_fail_n | output | 1 | Active-low latched terminal failure |

## Verification
Every result is due one cycle after the edge that samples its cause. The bench drives its inputs 1 ns after a rising edge and compares outputs 1 ns after the following edge. A bench model advances on the same edge, using the requirement rules and the state it held before that edge.

The model's new `status_word` draws on the message error, illegal flag and failure state from before the edge. A cause sampled at the same edge as the update therefore appears only at the next update. The bench checks this in the same way.

The freeze rule is checked against the previous cycle's observed word. Same-edge set-and-clear cases for the message error state and for the failure latch are driven directly.

// File: rtl/rt_status_pkg.sv
package rt_status_pkg;
  localparam int SW_W     = 16;
  localparam int RTA_W    = 5;
  localparam int ME_BIT   = 10;
  localparam int SR_BIT   = 8;
  localparam int DBCA_BIT = 1;
  localparam int TF_BIT   = 0;
  localparam int N_FAULT  = 2;
endpackage

// File: rtl/rt_cmd_track.sv
module rt_cmd_track (
  input  logic clk,
  input  logic rst,
  input  logic in_cmd,
  input  logic illegal_n,
  input  logic wc_mismatch,
  input  logic cmd_accept,
  output logic me_q,
  output logic ill_q
);
  logic in_cmd_d;
  logic rise;
  logic me_set;

  assign rise   = in_cmd & ~in_cmd_d;
  assign me_set = (rise & ~illegal_n) | wc_mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cmd_d <= 1'b0;
      ill_q    <= 1'b0;
      me_q     <= 1'b0;
    end else begin
      in_cmd_d <= in_cmd;
      if (rise) ill_q <= ~illegal_n;
      // set dominates a same-cycle clear
      me_q <= me_set | (me_q & ~cmd_accept);
    end
  end
endmodule

// File: rtl/rt_fail_latch.sv
module rt_fail_latch #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] fault,
  input  logic             tx_start,
  output logic             fail_q,
  output logic             fail_n
);
  logic any_fault;
  assign any_fault = |fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
      fail_n <= 1'b1;
    end else begin
      fail_q <= any_fault | (fail_q & ~tx_start);
      fail_n <= ~(any_fault | (fail_q & ~tx_start));
    end
  end
endmodule

// File: rtl/rt_status_reg.sv
module rt_status_reg
  import rt_status_pkg::*;
#(
  parameter int WORD_W = SW_W,
  parameter int ADDR_W = RTA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              update,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              me,
  input  logic              sr_n,
  input  logic              dbca_n,
  input  logic              dbc_valid,
  input  logic              ill,
  input  logic              tf,
  output logic [WORD_W-1:0] word
);
  localparam int ADDR_LSB = WORD_W - ADDR_W;

  logic [WORD_W-1:0] next_word;
  logic [WORD_W-1:0] flag_bits;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_LSB; gi++) begin : g_flag
      if (gi == ME_BIT) begin : g_me
        assign flag_bits[gi] = me;
      end else if (gi == SR_BIT) begin : g_sr
        assign flag_bits[gi] = ~sr_n;
      end else if (gi == DBCA_BIT) begin : g_dbca
        assign flag_bits[gi] = dbc_valid & ~dbca_n & ~ill;
      end else if (gi == TF_BIT) begin : g_tf
        assign flag_bits[gi] = tf;
      end else begin : g_zero
        assign flag_bits[gi] = 1'b0;
      end
    end
  endgenerate

  assign flag_bits[WORD_W-1:ADDR_LSB] = rt_addr;

  always_comb begin
    next_word = flag_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (update) word <= next_word;
  end
endmodule

// File: rtl/rt_status_builder.sv
module rt_status_builder
  import rt_status_pkg::*;
#(
  parameter int WORD_W = SW_W,
  parameter int ADDR_W = RTA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              in_cmd,
  input  logic              cmd_accept,
  input  logic              illegal_n,
  input  logic              wc_mismatch,
  input  logic              svc_req_n,
  input  logic              dbc_accept_n,
  input  logic              dbc_cmd_valid,
  input  logic              self_test_fail,
  input  logic              wd_timeout,
  input  logic              status_update,
  input  logic              status_tx_start,
  output logic [WORD_W-1:0] status_word,
  output logic              rt_fail_n
);
  logic me_q, ill_q, fail_q;
  logic [N_FAULT-1:0] faults;

  assign faults = {wd_timeout, self_test_fail};

  rt_cmd_track u_cmd (
    .clk(clk), .rst(rst), .in_cmd(in_cmd), .illegal_n(illegal_n),
    .wc_mismatch(wc_mismatch), .cmd_accept(cmd_accept),
    .me_q(me_q), .ill_q(ill_q)
  );

  rt_fail_latch #(.N_SRC(N_FAULT)) u_fail (
    .clk(clk), .rst(rst), .fault(faults), .tx_start(status_tx_start),
    .fail_q(fail_q), .fail_n(rt_fail_n)
  );

  rt_status_reg #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst(rst), .update(status_update), .rt_addr(rt_addr),
    .me(me_q), .sr_n(svc_req_n), .dbca_n(dbc_accept_n),
    .dbc_valid(dbc_cmd_valid), .ill(ill_q), .tf(fail_q),
    .word(status_word)
  );
endmodule

// File: rtl/rt_status_checker.sv
module rt_status_checker #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              svc_req_n,
  input logic              self_test_fail,
  input logic              wd_timeout,
  input logic              status_update,
  input logic              status_tx_start,
  input logic [WORD_W-1:0] status_word,
  input logic              rt_fail_n
);
  a_r2_addr: assert property (@(posedge clk) disable iff (rst)
    status_update |=> status_word[WORD_W-1:WORD_W-ADDR_W] == $past(rt_addr));

  a_r2_zero_bits: assert property (@(posedge clk) disable iff (rst)
    status_update |=> (status_word[9] == 1'b0 && status_word[7:2] == 6'd0));

  a_r3_service_req: assert property (@(posedge clk) disable iff (rst)
    status_update |=> status_word[8] == ~$past(svc_req_n));

  a_r7_fail_set: assert property (@(posedge clk) disable iff (rst)
    (self_test_fail || wd_timeout) |=> !rt_fail_n);

  a_r8_fail_clear: assert property (@(posedge clk) disable iff (rst)
    (status_tx_start && !self_test_fail && !wd_timeout) |=> rt_fail_n);

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    !status_update |=> $stable(status_word));
endmodule

bind rt_status_builder rt_status_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rt_addr(rt_addr), .svc_req_n(svc_req_n),
  .self_test_fail(self_test_fail), .wd_timeout(wd_timeout),
  .status_update(status_update), .status_tx_start(status_tx_start),
  .status_word(status_word), .rt_fail_n(rt_fail_n)
);

// File: tb/test_rt_status_builder.sv
`timescale 1ns/1ps
module test_rt_status_builder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] rt_addr = '0;
  logic in_cmd = 0, cmd_accept = 0, illegal_n = 1, wc_mismatch = 0;
  logic svc_req_n = 1, dbc_accept_n = 1, dbc_cmd_valid = 0;
  logic self_test_fail = 0, wd_timeout = 0, status_update = 0, status_tx_start = 0;
  logic [15:0] status_word;
  logic rt_fail_n;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rt_status_builder i_rt_status_builder (
    .clk(clk), .rst(rst), .rt_addr(rt_addr), .in_cmd(in_cmd),
    .cmd_accept(cmd_accept), .illegal_n(illegal_n), .wc_mismatch(wc_mismatch),
    .svc_req_n(svc_req_n), .dbc_accept_n(dbc_accept_n),
    .dbc_cmd_valid(dbc_cmd_valid), .self_test_fail(self_test_fail),
    .wd_timeout(wd_timeout), .status_update(status_update),
    .status_tx_start(status_tx_start), .status_word(status_word),
    .rt_fail_n(rt_fail_n)
  );

  // reference state
  logic m_in_d = 0, m_ill = 0, m_me = 0, m_fail = 0;
  logic [15:0] m_sw = '0;
  logic [15:0] prev_sw = '0;
  logic prev_upd = 0;

  function automatic logic [15:0] build_word(logic [4:0] a, logic me, logic srn,
                                             logic dn, logic dv, logic ill, logic tf);
    logic [15:0] w;
    w = '0;
    w[15:11] = a;
    w[10] = me;
    w[8] = ~srn;
    w[1] = dv & ~dn & ~ill;
    w[0] = tf;
    return w;
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic rise, n_me, n_fail, n_ill;
    logic [15:0] n_sw;
    @(posedge clk);
    prev_sw  = status_word;
    if (rst) begin
      m_in_d = 0; m_ill = 0; m_me = 0; m_fail = 0; m_sw = '0;
    end else begin
      rise  = in_cmd & ~m_in_d;
      n_ill = rise ? ~illegal_n : m_ill;
      n_me  = (rise & ~illegal_n) | wc_mismatch | (m_me & ~cmd_accept);
      n_fail = self_test_fail | wd_timeout | (m_fail & ~status_tx_start);
      n_sw  = status_update ? build_word(rt_addr, m_me, svc_req_n, dbc_accept_n,
                                         dbc_cmd_valid, m_ill, m_fail) : m_sw;
      m_in_d = in_cmd; m_ill = n_ill; m_me = n_me; m_fail = n_fail; m_sw = n_sw;
    end
    prev_upd = status_update & ~rst;
    #1;
    if (!rst) begin
      check("R2 address/zero bits", {status_word[15:11], 1'b0, status_word[9], 1'b0, status_word[7:2]},
            {m_sw[15:11], 1'b0, m_sw[9], 1'b0, m_sw[7:2]});
      check("R4/R5 message error bit", {15'd0, status_word[10]}, {15'd0, m_sw[10]});
      check("R3 service request bit", {15'd0, status_word[8]}, {15'd0, m_sw[8]});
      check("R6 bus control accept bit", {15'd0, status_word[1]}, {15'd0, m_sw[1]});
      check("R10 terminal flag bit", {15'd0, status_word[0]}, {15'd0, m_sw[0]});
      check("R7/R8 rt_fail_n", {15'd0, rt_fail_n}, {15'd0, ~m_fail});
      if (!prev_upd) check("R9 frozen word", status_word, prev_sw);
    end
  endtask

  task automatic idle();
    in_cmd = 0; cmd_accept = 0; illegal_n = 1; wc_mismatch = 0;
    svc_req_n = 1; dbc_accept_n = 1; dbc_cmd_valid = 0;
    self_test_fail = 0; wd_timeout = 0; status_update = 0; status_tx_start = 0;
  endtask

  task automatic upd_step();
    status_update = 1; step(); status_update = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    rst = 1; step(); step(); step();
    rst = 0;
    #1;
    check("R1 reset word", status_word, 16'h0000);
    check("R1 reset rt_fail_n", {15'd0, rt_fail_n}, 16'd1);

    // R3: service request low then high
    rt_addr = 5'h15; svc_req_n = 0; upd_step();
    check("R3 sr low sets bit8", {15'd0, status_word[8]}, 16'd1);
    svc_req_n = 1; upd_step();
    check("R3 sr high clears bit8", {15'd0, status_word[8]}, 16'd0);

    // R4: illegal captured on in_cmd rise
    illegal_n = 0; in_cmd = 1; step(); illegal_n = 1; step(); in_cmd = 0; step();
    upd_step();
    check("R4 illegal sets message error", {15'd0, status_word[10]}, 16'd1);

    // R6: illegal command blocks acceptance
    dbc_accept_n = 0; dbc_cmd_valid = 1; upd_step();
    check("R6 blocked by illegal", {15'd0, status_word[1]}, 16'd0);
    // new legal command
    in_cmd = 1; cmd_accept = 1; step(); cmd_accept = 0; step(); in_cmd = 0;
    upd_step();
    check("R5 cleared by cmd_accept", {15'd0, status_word[10]}, 16'd0);
    check("R6 accepted on legal command", {15'd0, status_word[1]}, 16'd1);
    dbc_cmd_valid = 0; upd_step();
    check("R6 not a bus control command", {15'd0, status_word[1]}, 16'd0);
    dbc_accept_n = 1;

    // R5: mismatch and clear in same cycle, set wins
    wc_mismatch = 1; cmd_accept = 1; step(); wc_mismatch = 0; cmd_accept = 0;
    upd_step();
    check("R5 set wins over clear", {15'd0, status_word[10]}, 16'd1);
    cmd_accept = 1; step(); cmd_accept = 0;

    // R7/R8/R10
    wd_timeout = 1; step(); wd_timeout = 0;
    check("R7 watchdog sets failure", {15'd0, rt_fail_n}, 16'd0);
    upd_step();
    check("R10 flag from latch", {15'd0, status_word[0]}, 16'd1);
    self_test_fail = 1; status_tx_start = 1; step(); status_tx_start = 0;
    check("R8 fault holds over tx start", {15'd0, rt_fail_n}, 16'd0);
    self_test_fail = 0; step();
    status_tx_start = 1; step(); status_tx_start = 0;
    check("R8 tx start clears latch", {15'd0, rt_fail_n}, 16'd1);

    // R9: freeze with busy inputs
    rt_addr = 5'h0A; svc_req_n = 0; wc_mismatch = 1; step(); step();
    wc_mismatch = 0; svc_req_n = 1;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      rt_addr         = 5'($urandom);
      in_cmd          = ($urandom % 3) == 0;
      cmd_accept      = ($urandom % 6) == 0;
      illegal_n       = ($urandom % 3) != 0;
      wc_mismatch     = ($urandom % 10) == 0;
      svc_req_n       = 1'($urandom);
      dbc_accept_n    = 1'($urandom);
      dbc_cmd_valid   = 1'($urandom);
      self_test_fail  = ($urandom % 20) == 0;
      wd_timeout      = ($urandom % 25) == 0;
      status_update   = ($urandom % 4) == 0;
      status_tx_start = ($urandom % 5) == 0;
      step();
    end
    idle();
    step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule